// File: doc/BRIEF.md
# Suspend and Resume Power Sequencer

This block sequences a USB device through its low-power states. While the device runs normally it times how long the USB bus has been quiet, using a free-running millisecond reference tick. After six quiet milliseconds it pulses an interrupt so firmware can decide to power down. Firmware requests power-down by writing a suspend bit. The block then drops both the oscillator enable and the internal clock enable and waits in suspend.

Leaving suspend needs no firmware action. Bus activity wakes the block if its wake enable is set. A change on any key input also wakes it if that enable is set. The block never goes straight back to normal operation. It first passes through a resume phase, where the oscillator enable is back on but the internal clock enable stays off. This lasts for a programmed number of millisecond ticks, which gives the oscillator time to settle before logic sees a clock. The block runs on an always-on reference clock, so wake detection works while the gated internal clock is stopped.

Top module: `susp_resume_seq`

## Requirements
- R1: After reset the state output `pwr_state` reads 0 (normal; suspend is 1, resume is 2). Both `osc_en` and `clk_en` are 1, and `idle_irq` and `susp_flag` are 0.
- R2: In normal state, `idle_irq` pulses high for exactly one cycle on the sixth `ms_tick` seen with `bus_active` low since the last bus activity. It does not pulse again until bus activity has occurred. A cycle with `bus_active` high resets the count.
- R3: In normal state, a write with `pwr_susp`=1 takes the block to suspend at the second clock edge after the write. In suspend, `osc_en` and `clk_en` are both 0. A write with `pwr_susp`=0 has no effect.
- R4: `susp_flag` is 1 only in the single cycle between an accepted suspend write and the suspend state. Suspend writes made in the suspend or resume state are ignored: the flag stays 0 and the state does not change.
- R5: In suspend, `bus_active` high moves the block to resume at the next edge only when bit 4 of the wake configuration is 1. Otherwise it is ignored.
- R6: In suspend, a change on any bit of `key_in` since the previous cycle moves the block to resume only when bit 5 of the wake configuration is 1. Otherwise it is ignored.
- R7: In resume, `osc_en` is 1 and `clk_en` is 0 for the whole interval. The block then returns to normal, where both are 1. Suspend always exits through resume.
- R8: The resume interval counts T `ms_tick` pulses, where T comes from the configuration field n in bits 3:0. The field is sampled when the block enters resume. T = n+1 for n<=11 and T = 2n-10 for n>=12, so the range runs 1 to 20. The block reaches normal at the edge that samples the T-th tick.
- R9: Re-entering normal from resume restarts the idle count from zero, so the next `idle_irq` follows six fresh idle ticks.
- R10: In normal state, `bus_active` and key changes never change the state, whatever the wake enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| bus_active | input | 1 | High while USB bus activity is seen |
| key_in | input | KEY_W | Key GPIO levels |
| pwr_wr | input | 1 | Power control write strobe |
| pwr_susp | input | 1 | Suspend bit (bit 0) of the power control write |
| wake_wr | input | 1 | Wake configuration write strobe |
| wake_wdata | input | 6 | Bit 5 key wake enable, bit 4 bus wake enable, bits 3:0 resume field |
| idle_irq | output | 1 | One-cycle bus-idle interrupt pulse |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Internal clock gate enable |
| susp_flag | output | 1 | Pending suspend bit, self-clearing |
| pwr_state | output | 2 | 0 normal, 1 suspend, 2 resume |

## Verification
The assertions assume that `ms_tick` is a single-cycle pulse and that every input changes only between clock edges. They also assume the wake configuration holds steady across the edge where resume is entered. The stimulus drives every input on the falling edge. Ticks come either every fourth cycle or at random with probability one in four. Because the resume field is latched on entry, configuration writes may land at any time, and random writes are allowed in all three states. Bus activity and key toggles are kept sparse so that idle interrupts, suspends and wakes all occur many times.

// File: rtl/susp_seq_pkg.sv
package susp_seq_pkg;
  typedef enum logic [1:0] {
    PS_NORMAL  = 2'd0,
    PS_SUSPEND = 2'd1,
    PS_RESUME  = 2'd2
  } pwr_state_e;

  localparam int unsigned RES_FIELD_W = 4;
  localparam int unsigned RES_CNT_W   = 5;

  // Resume length in ms ticks: step of 1 up to 12, then step of 2 up to 20.
  function automatic logic [RES_CNT_W-1:0] resume_ms(input logic [RES_FIELD_W-1:0] f);
    if (f <= 4'd11) return {1'b0, f} + 5'd1;
    else            return {f, 1'b0} - 5'd10;
  endfunction
endpackage

// File: rtl/susp_idle_timer.sv
module susp_idle_timer #(
  parameter int unsigned IDLE_MS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic normal,
  input  logic bus_active,
  input  logic ms_tick,
  output logic irq
);
  localparam int unsigned CW = $clog2(IDLE_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_MS - 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_MS);

  logic [CW-1:0] cnt_q;
  logic          reached;

  assign reached = normal && !bus_active && ms_tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= reached;
      if (!normal || bus_active) cnt_q <= '0;
      else if (ms_tick && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the interrupt is a single-cycle pulse
  a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R2: counter never passes its saturation value
  a_r2_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
endmodule

// File: rtl/susp_wake_detect.sv
module susp_wake_detect #(
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suspended,
  input  logic             en_bus,
  input  logic             en_key,
  input  logic             bus_active,
  input  logic [KEY_W-1:0] key_in,
  output logic             wake
);
  logic [KEY_W-1:0] key_prev_q;
  logic             key_changed;
  logic             bus_wake;
  logic             key_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_prev_q <= '0;
    else        key_prev_q <= key_in;
  end

  assign key_changed = |(key_in ^ key_prev_q);
  assign bus_wake    = en_bus && bus_active;
  assign key_wake    = en_key && key_changed;
  assign wake        = suspended && (bus_wake || key_wake);

  // R5 R6: a disabled source never produces a wake
  a_r5_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bus && !en_key) |-> !wake);
endmodule

// File: rtl/susp_resume_timer.sv
module susp_resume_timer
  import susp_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   active,
  input  logic                   ms_tick,
  input  logic [RES_FIELD_W-1:0] field,
  output logic                   done
);
  logic [RES_CNT_W-1:0] target_q;
  logic [RES_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= 5'd1;
      cnt_q    <= '0;
    end else begin
      if (start) target_q <= resume_ms(field);
      if (!active)      cnt_q <= '0;
      else if (ms_tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = active && ms_tick && (cnt_q == target_q - 5'd1);

  // R8: the elapsed count stays below the latched interval
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < target_q));
  // R8: interval always within 1..20
  a_r8_target_range: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q >= 5'd1) && (target_q <= 5'd20));
endmodule

// File: rtl/susp_resume_seq.sv
module susp_resume_seq
  import susp_seq_pkg::*;
#(
  parameter int unsigned KEY_W   = 8,
  parameter int unsigned IDLE_MS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             bus_active,
  input  logic [KEY_W-1:0] key_in,
  input  logic             pwr_wr,
  input  logic             pwr_susp,
  input  logic             wake_wr,
  input  logic [5:0]       wake_wdata,
  output logic             idle_irq,
  output logic             osc_en,
  output logic             clk_en,
  output logic             susp_flag,
  output logic [1:0]       pwr_state
);
  localparam int unsigned BIT_KEY_EN = 5;
  localparam int unsigned BIT_BUS_EN = 4;

  pwr_state_e state_q, state_d;
  logic [5:0] cfg_q;
  logic       flag_q;
  logic       wake;
  logic       res_done;
  logic       enter_res;

  assign enter_res = (state_q == PS_SUSPEND) && wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_NORMAL:  if (flag_q)    state_d = PS_SUSPEND;
      PS_SUSPEND: if (wake)      state_d = PS_RESUME;
      PS_RESUME:  if (res_done)  state_d = PS_NORMAL;
      default:                   state_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_NORMAL;
      cfg_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= (state_q == PS_NORMAL) && !flag_q && pwr_wr && pwr_susp;
      if (wake_wr) cfg_q <= wake_wdata;
    end
  end

  susp_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .normal     (state_q == PS_NORMAL),
    .bus_active (bus_active),
    .ms_tick    (ms_tick),
    .irq        (idle_irq)
  );

  susp_wake_detect #(.KEY_W(KEY_W)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .suspended  (state_q == PS_SUSPEND),
    .en_bus     (cfg_q[BIT_BUS_EN]),
    .en_key     (cfg_q[BIT_KEY_EN]),
    .bus_active (bus_active),
    .key_in     (key_in),
    .wake       (wake)
  );

  susp_resume_timer u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (enter_res),
    .active  (state_q == PS_RESUME),
    .ms_tick (ms_tick),
    .field   (cfg_q[RES_FIELD_W-1:0]),
    .done    (res_done)
  );

  assign osc_en    = (state_q != PS_SUSPEND);
  assign clk_en    = (state_q == PS_NORMAL);
  assign susp_flag = flag_q;
  assign pwr_state = state_q;

  // R3: a pending suspend bit always takes effect at the next edge
  a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_NORMAL && flag_q) |=> (state_q == PS_SUSPEND));
  // R7: suspend never jumps straight to normal
  a_r7_via_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SUSPEND) |=> (state_q != PS_NORMAL));
  // R5 R6: without a wake event suspend is held
  a_r6_hold_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SUSPEND && !wake) |=> (state_q == PS_SUSPEND));
  // R4: the flag is never set outside normal
  a_r4_flag_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_NORMAL) |=> !flag_q);
  // R10: normal is left only through a pending suspend
  a_r10_normal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_NORMAL && !flag_q) |=> (state_q == PS_NORMAL));
endmodule

// File: tb/susp_resume_seq_test.sv
module susp_resume_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, bus_active = 1'b0, pwr_wr = 1'b0, pwr_susp = 1'b0, wake_wr = 1'b0;
  logic [KW-1:0] key_in = '0;
  logic [5:0] wake_wdata = '0;
  logic idle_irq, osc_en, clk_en, susp_flag;
  logic [1:0] pwr_state;

  int checks = 0, errors = 0;
  int tick_phase = 0;
  bit rand_tick = 0;

  // reference model state
  int m_state, m_cnt, m_rcnt, m_target;
  bit m_flag, m_irq;
  logic [5:0] m_cfg;
  logic [KW-1:0] m_kprev;

  always #(CLK_PERIOD/2) clk = ~clk;

  susp_resume_seq #(.KEY_W(KW), .IDLE_MS(6)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_active(bus_active),
    .key_in(key_in), .pwr_wr(pwr_wr), .pwr_susp(pwr_susp), .wake_wr(wake_wr),
    .wake_wdata(wake_wdata), .idle_irq(idle_irq), .osc_en(osc_en),
    .clk_en(clk_en), .susp_flag(susp_flag), .pwr_state(pwr_state));

  function automatic int interval_of(int n);
    int t = (n < 12) ? n + 1 : 12 + 2 * (n - 11);
    return (t > 20) ? 20 : t;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int ns; bit wake;
    wake = (m_state == 1) && ((m_cfg[4] && bus_active) || (m_cfg[5] && key_in != m_kprev));
    ns = m_state;
    if (m_state == 0 && m_flag) ns = 1;
    else if (m_state == 1 && wake) ns = 2;
    else if (m_state == 2 && ms_tick && m_rcnt == m_target - 1) ns = 0;
    m_irq = (m_state == 0) && !bus_active && ms_tick && (m_cnt == 5);
    if (m_state != 0 || bus_active) m_cnt = 0;
    else if (ms_tick && m_cnt < 6) m_cnt++;
    if (m_state != 2) m_rcnt = 0; else if (ms_tick) m_rcnt++;
    if (m_state == 1 && wake) m_target = interval_of(int'(m_cfg[3:0]));
    m_flag = (m_state == 0) && !m_flag && pwr_wr && pwr_susp;
    if (wake_wr) m_cfg = wake_wdata;
    m_kprev = key_in;
    m_state = ns;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R3 R5 R6 state", int'(pwr_state), m_state);
    chk("R7 osc_en", int'(osc_en), int'(m_state != 1));
    chk("R7 clk_en", int'(clk_en), int'(m_state == 0));
    chk("R2 idle_irq", int'(idle_irq), int'(m_irq));
    chk("R4 susp_flag", int'(susp_flag), int'(m_flag));
    pwr_wr = 0; wake_wr = 0;
    if (rand_tick) ms_tick = ($urandom % 4) == 0;
    else begin
      tick_phase = (tick_phase + 1) % 4;
      ms_tick = (tick_phase == 0);
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic count_irq(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin step(); if (idle_irq) c++; end
  endtask

  task automatic write_cfg(logic [5:0] v);
    wake_wr = 1; wake_wdata = v; step();
  endtask

  task automatic go_suspend();
    pwr_wr = 1; pwr_susp = 1; step(); step();
    chk("R3 suspend entered", int'(pwr_state), 1);
  endtask

  task automatic run_resume(int exp_ms);
    int cnt = 0;
    for (int i = 0; i < 200 && pwr_state == 2; i++) begin
      bit counted = ms_tick;
      chk("R7 clk masked in resume", int'(clk_en), 0);
      chk("R7 osc on in resume", int'(osc_en), 1);
      step();
      if (counted) cnt++;
    end
    chk("R8 resume interval ticks", cnt, exp_ms);
    chk("R7 back to normal", int'(pwr_state), 0);
  endtask

  initial begin
    int c;
    void'($urandom(32'h5eed1234));
    m_state = 0; m_cnt = 0; m_rcnt = 0; m_target = 1;
    m_flag = 0; m_irq = 0; m_cfg = '0; m_kprev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset state", int'(pwr_state), 0);
    chk("R1 reset osc_en", int'(osc_en), 1);
    chk("R1 reset clk_en", int'(clk_en), 1);
    chk("R1 reset irq", int'(idle_irq), 0);
    chk("R1 reset flag", int'(susp_flag), 0);

    // R2: one pulse over a long idle stretch, then restart after activity
    count_irq(48, c); chk("R2 single idle pulse", c, 1);
    bus_active = 1; step(); bus_active = 0;
    count_irq(30, c); chk("R2 pulse after restart", c, 1);

    // R10: wake sources ignored in normal
    write_cfg(6'h3F);
    bus_active = 1; steps(3); key_in = 8'hA5; step(); bus_active = 0; steps(2);
    chk("R10 normal unaffected", int'(pwr_state), 0);

    // R3: write of zero ignored
    pwr_wr = 1; pwr_susp = 0; steps(3);
    chk("R3 zero write ignored", int'(pwr_state), 0);
    pwr_wr = 1; pwr_susp = 1; step();
    chk("R4 flag pending", int'(susp_flag), 1);
    step();
    chk("R3 in suspend", int'(pwr_state), 1);
    chk("R3 osc off", int'(osc_en), 0);
    chk("R4 flag cleared", int'(susp_flag), 0);

    // R4: write in suspend ignored
    pwr_wr = 1; pwr_susp = 1; step();
    chk("R4 suspend write ignored", int'(susp_flag), 0);
    write_cfg(6'h00);
    bus_active = 1; steps(3); bus_active = 0;
    chk("R5 bus wake disabled", int'(pwr_state), 1);
    key_in = 8'h5A; steps(2);
    chk("R6 key wake disabled", int'(pwr_state), 1);

    // R5 wake with n=12 -> 14 ticks
    write_cfg(6'h1C);
    bus_active = 1; step(); bus_active = 0;
    chk("R5 bus wake", int'(pwr_state), 2);
    pwr_wr = 1; pwr_susp = 1;
    run_resume(14);

    // R9: fresh idle count after resume
    count_irq(26, c); chk("R9 idle after resume", c, 1);

    // R6 key wake, n=15 -> 20; n=0 -> 1; n=5 -> 6
    go_suspend(); write_cfg(6'h2F); key_in[3] = ~key_in[3]; step();
    chk("R6 key wake", int'(pwr_state), 2);
    run_resume(20);
    go_suspend(); write_cfg(6'h20); key_in[0] = ~key_in[0]; step();
    run_resume(1);
    go_suspend(); write_cfg(6'h15); bus_active = 1; step(); bus_active = 0;
    run_resume(6);

    // random traffic against the model
    rand_tick = 1;
    for (int i = 0; i < 6000; i++) begin
      bus_active = ($urandom % 10) == 0;
      if (($urandom % 20) == 0) key_in = key_in ^ (8'h1 << ($urandom % KW));
      if (($urandom % 25) == 0) begin pwr_wr = 1; pwr_susp = ($urandom % 4) != 0; end
      if (($urandom % 30) == 0) begin wake_wr = 1; wake_wdata = 6'($urandom); end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule